// File: doc/BRIEF.md
# Dual-Frequency Quad-Phase NCO Core

This block is the phase-generation part of a direct digital synthesizer. A 32-bit accumulator adds one of two stored tuning words every clock. The top 12 bits of the accumulator, plus one of four stored 12-bit phase offsets, form the phase word that feeds a sine lookup. The output frequency is the tuning word times the clock rate divided by 2^32. Only tuning words that stay below half the clock rate give a usable waveform. One offset step equals 2π/4096 radians.

The tuning word and the phase offset can each be chosen in two ways. One way is a control register. The other is a pair of select pins, which suits frequency-shift and phase-shift keying. When the pins are used, a sync option samples them on a clock edge and applies the sampled value one cycle later. This keeps a pin change from taking effect in the middle of a cycle.

Three control bits gate operation, and all three are set after reset. The zero bit holds the accumulator at zero. The sleep bit freezes the accumulator and forces the phase word to zero. The clear bit empties the pin-sample registers. The core runs only when all three bits are low. All storage is loaded through one parallel write port.

Top module: `nco_core`

## Requirements
- R1: After reset, both tuning words, all four offsets, the accumulator and the pin-sample registers are zero. The control register has zero, sleep and clear set and every other bit low, so `run` is 0 and `phase_out` is 0.
- R2: A write with `ld_en` high updates storage from the next clock edge. Address 0 writes tuning word 0 and address 1 writes tuning word 1. Addresses 2 to 5 write phase offsets 0 to 3 from data bits 11:0. Address 6 writes the control register from data bits 7:0. A write to address 7 changes nothing.
- R3: When zero and sleep are both low, each clock edge adds the selected tuning word to the accumulator, modulo 2^32.
- R4: When sleep is low, `phase_out` equals accumulator bits 31:20 plus the selected phase offset, modulo 4096.
- R5: When control bit 3 (pin source) is low, control bit 0 selects the tuning word and control bits 2:1 select the phase offset.
- R6: When pin source is high and control bit 4 (sync) is low, `pin_fsel` and `pin_psel` select directly, in the same cycle.
- R7: When pin source and sync are both high, the pins are sampled at each clock edge. The sampled value makes the selection only after that edge, so a pin change first affects the accumulator step one edge later.
- R8: When control bit 6 (zero) is high, the accumulator is 0 after the next edge and stays 0. If sleep is low, `phase_out` then equals the selected offset.
- R9: When control bit 5 (sleep) is high and zero is low, the accumulator keeps its value and `phase_out` is 0. When sleep falls, accumulation resumes from the kept value.
- R10: When control bit 7 (clear) is high, the pin-sample registers load zero at every edge. Under sync, the selection is then tuning word 0 and offset 0.
- R11: `run` is high exactly when control bits 5, 6 and 7 are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write strobe for the storage port |
| ld_addr | input | 3 | Write address |
| ld_data | input | 32 | Write data |
| pin_fsel | input | 1 | External tuning-word select |
| pin_psel | input | 2 | External phase-offset select |
| phase_out | output | 12 | Phase word to the sine lookup |
| run | output | 1 | High when no gating control bit is set |

## Verification
A pin change and an accumulator step can fall on the same clock edge. The bench changes the select pins at random on every cycle with sync both off and on. Its model steps the accumulator with the direct pin value in the first case and with the previously sampled value in the second. A storage write and accumulation can also share an edge. The bench rewrites the active tuning word and an active offset while the core runs, and expects the old word for that edge and the new word from the next one.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Fixed bank sizes of the core
    localparam int N_FTW   = 2;
    localparam int N_POFF  = 4;
    localparam int FSEL_W  = $clog2(N_FTW);
    localparam int PSEL_W  = $clog2(N_POFF);
    localparam int ADDR_W  = 3;

    // Storage map
    localparam int FTW_BASE  = 0;
    localparam int POFF_BASE = FTW_BASE + N_FTW;
    localparam int CTRL_ADDR = POFF_BASE + N_POFF;

    // Control word; field order fixes bit positions (fsel is bit 0)
    typedef struct packed {
        logic              clr;
        logic              zero;
        logic              sleep;
        logic              sync;
        logic              use_pins;
        logic [PSEL_W-1:0] psel;
        logic [FSEL_W-1:0] fsel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RESET = '{clr: 1'b1, zero: 1'b1, sleep: 1'b1,
                                     sync: 1'b0, use_pins: 1'b0,
                                     psel: '0, fsel: '0};

    // Gating state of the core
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ZERO  = 2'd1,
        ST_SLEEP = 2'd2
    } acc_mode_e;

    function automatic acc_mode_e acc_mode(input ctrl_t c);
        if (c.zero)       return ST_ZERO;
        else if (c.sleep) return ST_SLEEP;
        else              return ST_RUN;
    endfunction

    function automatic logic gated(input ctrl_t c);
        return c.clr | c.zero | c.sleep;
    endfunction

endpackage

// File: rtl/nco_regs.sv
module nco_regs
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_en,
    input  logic [ADDR_W-1:0]         ld_addr,
    input  logic [ACC_W-1:0]          ld_data,
    output logic [ACC_W-1:0]          ftw  [N_FTW],
    output logic [PH_W-1:0]           poff [N_POFF],
    output ctrl_t                     ctl
);

    genvar g;
    generate
        for (g = 0; g < N_FTW; g++) begin : g_ftw
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(FTW_BASE + g);
            always_ff @(posedge clk) begin
                if (rst)                              ftw[g] <= '0;
                else if (ld_en && ld_addr == MY_ADDR) ftw[g] <= ld_data;
            end
        end
        for (g = 0; g < N_POFF; g++) begin : g_poff
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(POFF_BASE + g);
            always_ff @(posedge clk) begin
                if (rst)                              poff[g] <= '0;
                else if (ld_en && ld_addr == MY_ADDR) poff[g] <= ld_data[PH_W-1:0];
            end
        end
    endgenerate

    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst)                            ctl <= CTRL_RESET;
        else if (ld_en && ld_addr == CTL_A) ctl <= ctrl_t'(ld_data[CTRL_W-1:0]);
    end

    // R1: control word comes out of reset with all gates set
    a_r1_ctrl_reset: assert property (@(posedge clk)
        rst |=> (ctl == CTRL_RESET));

    // R2: the control word only changes through a write to its address
    a_r2_ctrl_stable: assert property (@(posedge clk) disable iff (rst)
        !(ld_en && ld_addr == CTL_A) |=> $stable(ctl));

endmodule

// File: rtl/nco_select.sv
module nco_select
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [FSEL_W-1:0] pin_fsel,
    input  logic [PSEL_W-1:0] pin_psel,
    output logic [FSEL_W-1:0] fsel,
    output logic [PSEL_W-1:0] psel
);

    logic [FSEL_W-1:0] cap_f;
    logic [PSEL_W-1:0] cap_p;

    // Pin sampling stage used by the sync option
    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cap_f <= '0;
            cap_p <= '0;
        end else begin
            cap_f <= pin_fsel;
            cap_p <= pin_psel;
        end
    end

    always_comb begin
        if (!ctl.use_pins) begin
            fsel = ctl.fsel;
            psel = ctl.psel;
        end else if (ctl.sync) begin
            fsel = cap_f;
            psel = cap_p;
        end else begin
            fsel = pin_fsel;
            psel = pin_psel;
        end
    end

    // R10: clear empties the sample stage
    a_r10_clear_cap: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (cap_f == '0 && cap_p == '0));

    // R7: without clear, the sample stage follows the pins one edge late
    a_r7_sample: assert property (@(posedge clk) disable iff (rst)
        !ctl.clr |=> (cap_f == $past(pin_fsel) && cap_p == $past(pin_psel)));

endmodule

// File: rtl/nco_accum.sv
module nco_accum
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctl,
    input  logic [ACC_W-1:0] ftw_sel,
    input  logic [PH_W-1:0]  poff_sel,
    output logic [ACC_W-1:0] acc_q,
    output logic [PH_W-1:0]  phase_out
);

    localparam int TOP_LSB = ACC_W - PH_W;

    acc_mode_e mode;
    assign mode = acc_mode(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            unique case (mode)
                ST_ZERO:  acc_q <= '0;
                ST_SLEEP: acc_q <= acc_q;
                default:  acc_q <= acc_q + ftw_sel;
            endcase
        end
    end

    logic [PH_W-1:0] ph_sum;
    assign ph_sum    = acc_q[ACC_W-1:TOP_LSB] + poff_sel;
    assign phase_out = ctl.sleep ? '0 : ph_sum;

    // R8: zero drives the accumulator to zero
    a_r8_zero_hold: assert property (@(posedge clk) disable iff (rst)
        ctl.zero |=> (acc_q == '0));

    // R9: sleep freezes the accumulator
    a_r9_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl.sleep && !ctl.zero) |=> $stable(acc_q));

endmodule

// File: rtl/nco_core.sv
module nco_core
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [2:0]        ld_addr,
    input  logic [ACC_W-1:0]  ld_data,
    input  logic              pin_fsel,
    input  logic [1:0]        pin_psel,
    output logic [PH_W-1:0]   phase_out,
    output logic              run
);

    logic [ACC_W-1:0]  ftw  [N_FTW];
    logic [PH_W-1:0]   poff [N_POFF];
    ctrl_t             ctl;
    logic [FSEL_W-1:0] fsel;
    logic [PSEL_W-1:0] psel;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  ftw_sel;
    logic [PH_W-1:0]   poff_sel;

    nco_regs #(.ACC_W(ACC_W), .PH_W(PH_W)) u_regs (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .ftw(ftw), .poff(poff), .ctl(ctl)
    );

    nco_select u_sel (
        .clk(clk), .rst(rst), .ctl(ctl),
        .pin_fsel(pin_fsel), .pin_psel(pin_psel),
        .fsel(fsel), .psel(psel)
    );

    assign ftw_sel  = ftw[fsel];
    assign poff_sel = poff[psel];

    nco_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk(clk), .rst(rst), .ctl(ctl), .ftw_sel(ftw_sel),
        .poff_sel(poff_sel), .acc_q(acc_q), .phase_out(phase_out)
    );

    assign run = !gated(ctl);

    // R3: while running, the accumulator advances by the banked word chosen
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (!ctl.zero && !ctl.sleep) |=> (acc_q == $past(acc_q) + $past(ftw[fsel])));

    // R5: register source follows control bits
    a_r5_reg_src: assert property (@(posedge clk) disable iff (rst)
        !ctl.use_pins |-> (fsel == ctl.fsel && psel == ctl.psel));

endmodule

// File: tb/tb_nco_core.sv
`timescale 1ns/1ps
module tb_nco_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        pin_fsel = 1'b0;
    logic [1:0]  pin_psel = '0;
    logic [11:0] phase_out;
    logic        run;

    always #2.5 clk = ~clk;

    nco_core dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .pin_fsel(pin_fsel), .pin_psel(pin_psel),
        .phase_out(phase_out), .run(run)
    );

    // control bit positions (R2, R5..R11)
    localparam logic [7:0] C_FSEL = 8'h01, C_PINS = 8'h08, C_SYNC = 8'h10,
                           C_SLEEP = 8'h20, C_ZERO = 8'h40, C_CLR = 8'h80;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_acc;
    logic [31:0] m_ftw [2];
    logic [11:0] m_poff [4];
    logic [7:0]  m_ctl;
    logic        m_capf;
    logic [1:0]  m_capp;

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Checks outputs against the model, then advances the model over one edge.
    task automatic step(input string req);
        logic       fs;
        logic [1:0] ps;
        logic [11:0] e_ph;
        #1;
        if (!m_ctl[3])      begin fs = m_ctl[0]; ps = m_ctl[2:1]; end
        else if (m_ctl[4])  begin fs = m_capf;   ps = m_capp;     end
        else                begin fs = pin_fsel; ps = pin_psel;   end
        e_ph = m_ctl[5] ? 12'h000 : 12'(m_acc[31:20] + m_poff[ps]);
        check(req, "phase_out", 32'(phase_out), 32'(e_ph));
        check("R11", "run", 32'(run), 32'(!(m_ctl[5] | m_ctl[6] | m_ctl[7])));
        // edge update
        if (m_ctl[6])       m_acc = '0;
        else if (!m_ctl[5]) m_acc = m_acc + m_ftw[fs];
        if (m_ctl[7]) begin m_capf = 0; m_capp = 0; end
        else begin m_capf = pin_fsel; m_capp = pin_psel; end
        if (ld_en) begin
            case (ld_addr)
                3'd0, 3'd1: m_ftw[ld_addr[0]] = ld_data;
                3'd2, 3'd3, 3'd4, 3'd5: m_poff[2'(ld_addr - 3'd2)] = ld_data[11:0];
                3'd6: m_ctl = ld_data[7:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic load(input logic [2:0] a, input logic [31:0] d, input string req);
        ld_en = 1; ld_addr = a; ld_data = d;
        step(req);
        ld_en = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        m_acc = '0; m_ftw[0] = '0; m_ftw[1] = '0;
        for (int i = 0; i < 4; i++) m_poff[i] = '0;
        m_ctl = C_SLEEP | C_ZERO | C_CLR; m_capf = 0; m_capp = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", "phase_out", 32'(phase_out), 0);
        check("R1", "run", 32'(run), 0);
        step("R1");
        // R8: zero with sleep released shows the offset
        load(3'd2, 32'hFFFF_F123, "R2");
        load(3'd6, 32'(C_ZERO), "R8");
        repeat (4) step("R8");
        // R2: banks
        load(3'd0, 32'h0123_4567, "R2");
        load(3'd1, 32'h8000_0001, "R2");
        load(3'd3, 32'h0000_03FF, "R2");
        load(3'd4, 32'h0000_0800, "R2");
        load(3'd5, 32'h0000_0FFF, "R2");
        // R3 R4 R5: sweep register selects
        for (int f = 0; f < 2; f++)
            for (int p = 0; p < 4; p++) begin
                load(3'd6, 32'(f) | 32'(p << 1), "R5");
                repeat (20) step("R3");
            end
        // R6: direct pins
        load(3'd6, 32'(C_PINS), "R6");
        for (int i = 0; i < 200; i++) begin
            pin_fsel = 1'($urandom); pin_psel = 2'($urandom);
            step("R6");
        end
        // R7: sampled pins
        load(3'd6, 32'(C_PINS | C_SYNC), "R7");
        for (int i = 0; i < 200; i++) begin
            pin_fsel = 1'($urandom); pin_psel = 2'($urandom);
            step("R7");
        end
        // R10: clear empties the samples
        pin_fsel = 1; pin_psel = 3;
        load(3'd6, 32'(C_PINS | C_SYNC | C_CLR), "R10");
        for (int i = 0; i < 30; i++) begin
            pin_fsel = 1'($urandom); pin_psel = 2'($urandom);
            step("R10");
        end
        // R9: sleep holds, then resumes
        load(3'd6, 32'(C_SLEEP | C_FSEL), "R9");
        repeat (30) step("R9");
        load(3'd6, 32'(C_FSEL | 8'h04), "R9");
        repeat (30) step("R9");
        // R2: writes to the active word and offset while running; address 7 ignored
        load(3'd1, 32'hFFFF_FFF0, "R2");
        repeat (5) step("R2");
        load(3'd4, 32'h0000_0123, "R2");
        repeat (5) step("R2");
        load(3'd7, 32'hFFFF_FFFF, "R2");
        repeat (10) step("R2");
        // R8: zero while sleeping and then release
        load(3'd6, 32'(C_ZERO | C_SLEEP), "R8");
        repeat (5) step("R8");
        load(3'd6, 32'h0, "R8");
        repeat (20) step("R3");
        report();
    end

endmodule